// File: doc/BRIEF.md
# Timed-Access Write Guard

This unit protects a small set of critical control bits, such as watchdog enables or reset-cause flags, from stray software writes. It watches a register-bus write port and a machine-cycle enable pulse. Software unlocks it by writing two key bytes in a row to a dedicated key register: first AAh, which arms a short wait, then 55h. If the second key lands soon enough, a write window opens. It closes by itself after a few machine cycles.

While the window is open, a write to the protected register is accepted. At any other time such a write is dropped without any error indication. Both the arming wait and the window length are counted in machine cycles, using the `mc_tick` pulse, and not in clocks. A protected write or a key write that lands on the final counted tick still counts. The protected register is part of the block so that the gating can be seen at the ports.

Top module: `ta_guard`

## Requirements
- R1: While reset is asserted, and after it is released, `win_open` is 0 and `prot_q` holds its reset value (00h by default).
- R2: A write of AAh to the key register (address C7h) arms the unit. A write of 55h to C7h while armed opens the window. Armed means the write lands no later than the third `mc_tick` after the AAh write. `win_open` goes high on the clock after the 55h write.
- R3: A 55h write that lands on the fourth `mc_tick` after the AAh write, or later, does not open the window.
- R4: Once open, the window stays open through the third `mc_tick` after the opening write and is low on the clock after that tick. Clocks without `mc_tick` do not shorten it.
- R5: A write to the protected register (address D8h) while `win_open` is high loads `wr_data` into `prot_q` on the next clock. This includes a write on the window's last tick.
- R6: A write to D8h while `win_open` is low leaves `prot_q` unchanged.
- R7: A write to C7h with any value other than AAh or 55h closes the window and cancels any pending arm.
- R8: A 55h write to C7h while not armed leaves the window closed.
- R9: An AAh write while armed restarts the three-tick wait. An AAh write while the window is open closes the window and re-arms the unit.
- R10: After the window closes, a protected write is discarded until a complete AAh-then-55h sequence has been written again.
- R11: Writes to any other address change neither `win_open` nor `prot_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | One-clock pulse marking each machine cycle |
| wr_en | input | 1 | Register-bus write strobe |
| wr_addr | input | 8 | Register-bus write address |
| wr_data | input | 8 | Register-bus write data |
| win_open | output | 1 | Protected-write window is open |
| prot_q | output | 8 | Contents of the protected register |

## Verification
The assertions are checked on every cycle. They cover the following:
- the protected register changes only through a write made while the window is open, and it takes the written value;
- the window rises only after a 55h key write;
- an unexpected key value closes the window;
- the window never outlives three machine ticks.

Only the bench's scenarios can show the exact timing edges. These are a 55h write on the third tick being accepted and one on the fourth being rejected, a protected write on the last tick of the window versus the first tick after it, restarting the wait with a second AAh, and counting ticks rather than clocks.

// File: rtl/ta_pkg.sv
package ta_pkg;
  typedef enum logic [1:0] {
    TA_IDLE  = 2'd0,
    TA_ARMED = 2'd1,
    TA_OPEN  = 2'd2
  } ta_state_e;

  typedef struct packed {
    logic arm;      // first key seen on the key register
    logic unlock;   // second key seen on the key register
    logic other;    // any other value written to the key register
    logic prot_wr;  // write aimed at the protected register
  } ta_evt_t;
endpackage

// File: rtl/ta_rst_sync.sv
module ta_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ta_key_decode.sv
module ta_key_decode
  import ta_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 8,
  parameter int unsigned        DATA_W     = 8,
  parameter logic [ADDR_W-1:0]  KEY_ADDR   = 8'hC7,
  parameter logic [ADDR_W-1:0]  PROT_ADDR  = 8'hD8,
  parameter logic [DATA_W-1:0]  KEY_FIRST  = 8'hAA,
  parameter logic [DATA_W-1:0]  KEY_SECOND = 8'h55
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ta_evt_t           evt
);
  logic key_hit;
  logic is_first;
  logic is_second;

  always_comb begin
    key_hit     = wr_en && (wr_addr == KEY_ADDR);
    is_first    = (wr_data == KEY_FIRST);
    is_second   = (wr_data == KEY_SECOND);
    evt.arm     = key_hit && is_first;
    evt.unlock  = key_hit && is_second;
    evt.other   = key_hit && !is_first && !is_second;
    evt.prot_wr = wr_en && (wr_addr == PROT_ADDR);
  end
endmodule

// File: rtl/ta_seq_fsm.sv
module ta_seq_fsm
  import ta_pkg::*;
#(
  parameter int unsigned ARM_MC  = 3,
  parameter int unsigned OPEN_MC = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mc_tick,
  input  ta_evt_t evt,
  output logic    win_open
);
  localparam int unsigned MAX_MC = (ARM_MC > OPEN_MC) ? ARM_MC : OPEN_MC;
  localparam int unsigned CNT_W  = $clog2(MAX_MC + 1);
  localparam logic [CNT_W-1:0] ARM_LOAD  = CNT_W'(ARM_MC);
  localparam logic [CNT_W-1:0] OPEN_LOAD = CNT_W'(OPEN_MC);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  ta_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  // Key writes take priority over expiry in the same clock, so a write
  // landing on the final counted tick still acts on the current state.
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    upd_en  = 1'b0;
    if (evt.arm) begin
      upd_en  = 1'b1;
      state_d = TA_ARMED;
      cnt_d   = ARM_LOAD;
    end else if (evt.unlock) begin
      upd_en = 1'b1;
      if (state_q == TA_ARMED) begin
        state_d = TA_OPEN;
        cnt_d   = OPEN_LOAD;
      end else begin
        state_d = TA_IDLE;
        cnt_d   = '0;
      end
    end else if (evt.other) begin
      upd_en  = 1'b1;
      state_d = TA_IDLE;
      cnt_d   = '0;
    end else if (mc_tick && (state_q != TA_IDLE)) begin
      upd_en = 1'b1;
      if (cnt_q <= CNT_ONE) begin
        state_d = TA_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TA_IDLE;
      cnt_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign win_open = (state_q == TA_OPEN);
endmodule

// File: rtl/ta_prot_reg.sv
module ta_prot_reg #(
  parameter int unsigned        DATA_W  = 8,
  parameter logic [DATA_W-1:0]  RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              win_open,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q
);
  logic              ld_en;
  logic [DATA_W-1:0] q_d;

  always_comb begin
    ld_en = wr_req && win_open;
    q_d   = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (ld_en) begin
      q <= q_d;
    end
  end
endmodule

// File: rtl/ta_guard.sv
module ta_guard
  import ta_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 8,
  parameter int unsigned        DATA_W     = 8,
  parameter logic [ADDR_W-1:0]  KEY_ADDR   = 8'hC7,
  parameter logic [ADDR_W-1:0]  PROT_ADDR  = 8'hD8,
  parameter logic [DATA_W-1:0]  KEY_FIRST  = 8'hAA,
  parameter logic [DATA_W-1:0]  KEY_SECOND = 8'h55,
  parameter int unsigned        ARM_MC     = 3,
  parameter int unsigned        OPEN_MC    = 3,
  parameter logic [DATA_W-1:0]  PROT_RST   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              win_open,
  output logic [DATA_W-1:0] prot_q
);
  logic    rst_sync_n;
  ta_evt_t evt;

  ta_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ta_key_decode #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .KEY_ADDR   (KEY_ADDR),
    .PROT_ADDR  (PROT_ADDR),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .evt     (evt)
  );

  ta_seq_fsm #(
    .ARM_MC  (ARM_MC),
    .OPEN_MC (OPEN_MC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mc_tick  (mc_tick),
    .evt      (evt),
    .win_open (win_open)
  );

  ta_prot_reg #(
    .DATA_W  (DATA_W),
    .RST_VAL (PROT_RST)
  ) u_prot (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_req   (evt.prot_wr),
    .win_open (win_open),
    .wr_data  (wr_data),
    .q        (prot_q)
  );
endmodule

// File: rtl/ta_guard_chk.sv
module ta_guard_chk #(
  parameter int unsigned        ADDR_W     = 8,
  parameter int unsigned        DATA_W     = 8,
  parameter logic [ADDR_W-1:0]  KEY_ADDR   = 8'hC7,
  parameter logic [ADDR_W-1:0]  PROT_ADDR  = 8'hD8,
  parameter logic [DATA_W-1:0]  KEY_SECOND = 8'h55,
  parameter int unsigned        OPEN_MC    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mc_tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              win_open,
  input logic [DATA_W-1:0] prot_q
);
  localparam int unsigned OT_W = $clog2(OPEN_MC + 2);
  localparam logic [OT_W-1:0] OT_LIM = OT_W'(OPEN_MC);

  logic [OT_W-1:0] open_ticks;

  // Counts ticks seen while the window is open.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_ticks <= '0;
    end else if (!win_open) begin
      open_ticks <= '0;
    end else if (mc_tick) begin
      open_ticks <= open_ticks + OT_W'(1);
    end
  end

  // R1: window closed during reset
  a_r1_reset_closed: assert property (@(posedge clk) !rst_n |-> !win_open);

  // R2: window only rises after a second-key write
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(wr_en && (wr_addr == KEY_ADDR) && (wr_data == KEY_SECOND)));

  // R4: window never outlives its tick budget
  a_r4_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> (open_ticks < OT_LIM));

  // R5: an accepted protected write lands
  a_r5_prot_load: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && wr_en && (wr_addr == PROT_ADDR)) |=> (prot_q == $past(wr_data)));

  // R6: protected register moves only through an accepted write
  a_r6_prot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_open && wr_en && (wr_addr == PROT_ADDR)) |=> $stable(prot_q));

  // R7: any key-register value other than the second key leaves it closed
  a_r7_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == KEY_ADDR) && (wr_data != KEY_SECOND)) |=> !win_open);
endmodule

bind ta_guard ta_guard_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .KEY_ADDR   (KEY_ADDR),
  .PROT_ADDR  (PROT_ADDR),
  .KEY_SECOND (KEY_SECOND),
  .OPEN_MC    (OPEN_MC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .mc_tick  (mc_tick),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .win_open (win_open),
  .prot_q   (prot_q)
);

// File: tb/ta_guard_test.sv
module ta_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int MC_CLKS    = 3;
  localparam int WD_CYCLES  = 5000;

  typedef struct packed {
    logic       we;
    logic [7:0] a;
    logic [7:0] d;
    logic       op;
    logic [7:0] pq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t TBL [0:NV-1] = '{
    '{1'b1, 8'hC7, 8'hAA, 1'b0, 8'h00, 4'd2},  // R2 arm
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 4'd2},
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 4'd2},
    '{1'b1, 8'hC7, 8'h55, 1'b1, 8'h00, 4'd2},  // R2 gap of 3 ticks accepted
    '{1'b1, 8'hD8, 8'h11, 1'b1, 8'h11, 4'd5},  // R5
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h11, 4'd4},
    '{1'b1, 8'hD8, 8'h22, 1'b0, 8'h22, 4'd5},  // R5 last tick, R4 close
    '{1'b1, 8'hD8, 8'h33, 1'b0, 8'h22, 4'd6},  // R6 first tick after
    '{1'b1, 8'hC7, 8'h55, 1'b0, 8'h22, 4'd8},  // R8 lone second key
    '{1'b1, 8'hD8, 8'h44, 1'b0, 8'h22, 4'd10}, // R10
    '{1'b1, 8'hC7, 8'hAA, 1'b0, 8'h22, 4'd3},
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'h22, 4'd3},
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'h22, 4'd3},
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'h22, 4'd3},
    '{1'b1, 8'hC7, 8'h55, 1'b0, 8'h22, 4'd3},  // R3 gap of 4 ticks rejected
    '{1'b1, 8'hD8, 8'h5C, 1'b0, 8'h22, 4'd3},
    '{1'b1, 8'hC7, 8'hAA, 1'b0, 8'h22, 4'd9},
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'h22, 4'd9},
    '{1'b1, 8'hC7, 8'hAA, 1'b0, 8'h22, 4'd9},  // R9 restart
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'h22, 4'd9},
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'h22, 4'd9},
    '{1'b1, 8'hC7, 8'h55, 1'b1, 8'h22, 4'd9},  // R9 accepted from restart
    '{1'b1, 8'hC7, 8'h12, 1'b0, 8'h22, 4'd7},  // R7 closes window
    '{1'b1, 8'hD8, 8'h66, 1'b0, 8'h22, 4'd7},
    '{1'b1, 8'hC7, 8'hAA, 1'b0, 8'h22, 4'd7},
    '{1'b1, 8'hC7, 8'h5A, 1'b0, 8'h22, 4'd7},  // R7 cancels arm
    '{1'b1, 8'hC7, 8'h55, 1'b0, 8'h22, 4'd7},
    '{1'b1, 8'hC7, 8'hAA, 1'b0, 8'h22, 4'd2},
    '{1'b1, 8'hC7, 8'h55, 1'b1, 8'h22, 4'd2},  // R2 gap of 1 tick
    '{1'b1, 8'hD9, 8'h77, 1'b1, 8'h22, 4'd11}, // R11 other address
    '{1'b1, 8'hC7, 8'hAA, 1'b0, 8'h22, 4'd9},  // R9 first key closes window
    '{1'b1, 8'hC7, 8'h55, 1'b1, 8'h22, 4'd9},
    '{1'b1, 8'hD8, 8'h99, 1'b1, 8'h99, 4'd5},
    '{1'b0, 8'h00, 8'h00, 1'b1, 8'h99, 4'd4},
    '{1'b0, 8'h00, 8'h00, 1'b0, 8'h99, 4'd4}   // R4 closed after third tick
  };

  logic       clk;
  logic       rst_n;
  logic       mc_tick;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       win_open;
  logic [7:0] prot_q;

  int  n_checks;
  int  n_errors;
  bit  finished;

  ta_guard uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mc_tick  (mc_tick),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .win_open (win_open),
    .prot_q   (prot_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One machine cycle: tick with optional write on its first clock.
  task automatic mcycle(input logic we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    mc_tick = 1'b1;
    wr_en   = we;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    mc_tick = 1'b0;
    wr_en   = 1'b0;
    repeat (MC_CLKS - 1) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    mc_tick  = 1'b0;
    wr_en    = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    repeat (3) @(negedge clk);
    check("R1", "win_open in reset", {7'd0, win_open}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "win_open after reset", {7'd0, win_open}, 8'h00);
    check("R1", "prot_q after reset", prot_q, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      mcycle(TBL[i].we, TBL[i].a, TBL[i].d);
      tag = $sformatf("R%0d step %0d", TBL[i].req, i);
      check(tag, "win_open", {7'd0, win_open}, {7'd0, TBL[i].op});
      check(tag, "prot_q", prot_q, TBL[i].pq);
    end

    // R2/R4: timing counts machine ticks, not clocks.
    mcycle(1'b1, 8'hC7, 8'hAA);
    repeat (10) @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'hC7; wr_data = 8'h55;  // no tick on this clock
    @(negedge clk);
    wr_en = 1'b0;
    check("R2", "open after long tickless wait", {7'd0, win_open}, 8'h01);
    repeat (20) @(negedge clk);
    check("R4", "window held without ticks", {7'd0, win_open}, 8'h01);
    wr_en = 1'b1; wr_addr = 8'hD8; wr_data = 8'hA5;
    @(negedge clk);
    wr_en = 1'b0;
    check("R5", "write between ticks", prot_q, 8'hA5);

    // R1: reset in the middle of an open window.
    rst_n = 1'b0;
    #1;
    check("R1", "win_open on async reset", {7'd0, win_open}, 8'h00);
    check("R1", "prot_q on async reset", prot_q, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mcycle(1'b1, 8'hC7, 8'h55);
    check("R8", "no reopen after reset", {7'd0, win_open}, 8'h00);

    finish_run();
  end
endmodule